// File: doc/BRIEF.md
# Host-Loaded Colour Lookup Table with Streaming Index

This block holds a 256-entry table of 24-bit colours and translates 8-bit pixel codes into red, green and blue values for the display path. A host loads the table through two write targets. An index target sets the entry where the next colour lands. A colour target takes a packed word, stores it at that entry and then advances the index by one. A host can therefore load the whole table by writing the index once and then streaming 256 colour words. An identity ramp, where entry i holds i on every channel, is the usual content when the display runs at a direct-colour depth above 8 bpp.

The display side presents one pixel code every cycle. The matching colour appears on the output one clock later. A mode input selects full 8-bit channels or narrow 6-bit channels. In narrow mode the two lowest bits of each channel are driven to zero. The mode is registered together with the pixel code, so each output word is formatted with the mode that was present on its own lookup cycle.

Top module: `pixel_lut`

## Requirements
- R1: While reset is asserted and right after it is released, `pix_rgb` is zero. The index is zero after reset, so the first colour write stores into entry 0.
- R2: A host write with `host_sel`=0 loads `host_wdata[7:0]` into the index. The next colour write stores into that entry.
- R3: A host write with `host_sel`=1 stores blue from `host_wdata[7:0]`, green from `host_wdata[15:8]` and red from `host_wdata[23:16]`. Bits 31:24 are ignored. `pix_rgb` uses the same layout: red in 23:16, green in 15:8, blue in 7:0.
- R4: Every colour write increments the index by one, so consecutive colour writes fill consecutive entries.
- R5: The index wraps from 255 to 0 on a colour write.
- R6: The colour of the entry addressed by `pix_idx` on one clock edge appears on `pix_rgb` after that edge and holds until the next edge.
- R7: When `wide_en` is 1 on the lookup edge, each channel is output with all 8 stored bits. When `wide_en` is 0, bits 1:0 of each channel are output as zero and bits 7:2 are unchanged.
- R8: When a colour write and a lookup of the same entry occur in the same cycle, the lookup returns the colour held before the write. A lookup in the following cycle returns the new colour.
- R9: An index write leaves every table entry unchanged.
- R10: While `host_we` is 0, the values on `host_sel` and `host_wdata` change neither the index nor the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one write per cycle |
| host_sel | input | 1 | Write target: 0 = index, 1 = colour |
| host_wdata | input | 32 | Host write data |
| wide_en | input | 1 | 1 = 8-bit channels, 0 = 6-bit channels |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Colour of the code looked up on the previous edge |

## Verification
Each lookup is due exactly one clock after the edge that captures its pixel code and mode. Host writes take effect on their own edge, so a lookup driven in a later cycle sees the new data, while a lookup in the same cycle sees the old data. The driver applies all inputs at the falling edge. For each lookup it queues the expected colour, taken from a reference table before that cycle's write is applied, and marks it due one cycle later. The monitor compares at the falling edge of the due cycle, so every sample is taken half a period away from the edge that produced it.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int CH_W     = 8;
  localparam int NARROW_W = 6;
  localparam int N_CH     = 3;
  localparam int RGB_W    = CH_W * N_CH;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
  } rgb_t;

  function automatic rgb_t unpack_word(input logic [RGB_W-1:0] w);
    rgb_t v;
    v.red   = w[3*CH_W-1:2*CH_W];
    v.green = w[2*CH_W-1:CH_W];
    v.blue  = w[CH_W-1:0];
    return v;
  endfunction
endpackage

// File: rtl/palette_index.sv
module palette_index #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step_en,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_nxt;
  logic             idx_en;

  always_comb begin
    idx_en  = load_en | step_en;
    idx_nxt = idx;
    if (load_en) begin
      idx_nxt = load_val;
    end else if (step_en) begin
      idx_nxt = idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_nxt;
    end
  end
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  rgb_t             wr_rgb,
  input  logic [IDX_W-1:0] rd_addr,
  output rgb_t             rd_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  rgb_t mem [DEPTH];
  rgb_t rd_nxt;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_rgb;
    end
  end

  always_comb begin
    rd_nxt = mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_rgb <= '0;
    end else begin
      rd_rgb <= rd_nxt;
    end
  end
endmodule

// File: rtl/palette_fmt.sv
module palette_fmt
  import palette_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_in,
  input  rgb_t             rgb_in,
  output logic [RGB_W-1:0] rgb_out
);
  localparam int DROP = CH_W - NARROW_W;

  logic             wide_q;
  logic [RGB_W-1:0] flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b1;
    end else begin
      wide_q <= wide_in;
    end
  end

  assign flat = rgb_in;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    assign rgb_out[c*CH_W +: CH_W] = wide_q ? flat[c*CH_W +: CH_W]
                                            : {flat[c*CH_W+DROP +: NARROW_W], {DROP{1'b0}}};
  end
endmodule

// File: rtl/pixel_lut.sv
module pixel_lut
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              wide_en,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_rgb
);
  logic             idx_load;
  logic             colour_wr;
  logic [IDX_W-1:0] cur_idx;
  rgb_t             wr_rgb;
  rgb_t             rd_rgb;
  logic             unused_hi_bits;

  assign idx_load       = host_we & ~host_sel;
  assign colour_wr      = host_we & host_sel;
  assign wr_rgb         = unpack_word(host_wdata[RGB_W-1:0]);
  assign unused_hi_bits = ^host_wdata[DATA_W-1:RGB_W];

  palette_index #(.IDX_W(IDX_W)) i_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (idx_load),
    .load_val(host_wdata[IDX_W-1:0]),
    .step_en (colour_wr),
    .idx     (cur_idx)
  );

  palette_store #(.IDX_W(IDX_W)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (colour_wr),
    .wr_addr(cur_idx),
    .wr_rgb (wr_rgb),
    .rd_addr(pix_idx),
    .rd_rgb (rd_rgb)
  );

  palette_fmt i_fmt (
    .clk    (clk),
    .rst_n  (rst_n),
    .wide_in(wide_en),
    .rgb_in (rd_rgb),
    .rgb_out(pix_rgb)
  );
endmodule

// File: rtl/pixel_lut_chk.sv
module pixel_lut_chk #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic              host_sel,
  input logic [DATA_W-1:0] host_wdata,
  input logic              wide_en,
  input logic [23:0]       pix_rgb,
  input logic [IDX_W-1:0]  cur_idx
);
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel) |=> cur_idx == IDX_W'($past(cur_idx) + IDX_W'(1))); // R4

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_sel) |=> cur_idx == $past(host_wdata[IDX_W-1:0])); // R2

  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> $stable(cur_idx)); // R10

  AST_NARROW_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_en |=> (pix_rgb & 24'h030303) == 24'h0); // R7

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel && (&cur_idx)) |=> cur_idx == '0); // R5
endmodule

bind pixel_lut pixel_lut_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_we   (host_we),
  .host_sel  (host_sel),
  .host_wdata(host_wdata),
  .wide_en   (wide_en),
  .pix_rgb   (pix_rgb),
  .cur_idx   (cur_idx)
);

// File: tb/test_pixel_lut.sv
module test_pixel_lut;
  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic        host_sel;
  logic [31:0] host_wdata;
  logic        wide_en;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [23:0] exp;
    string       tag;
    int          due;
  } item_t;

  item_t       sbq[$];
  logic [23:0] model [256];
  logic [7:0]  m_idx;

  pixel_lut i_pixel_lut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .wide_en(wide_en), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  initial clk = 0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
    end
  endtask

  // One bus cycle: host write (optional) plus a lookup, expectation queued.
  task automatic step(input bit we, input bit sel, input logic [31:0] wd,
                      input logic [7:0] px, input bit wide, input bit chk, input string tag);
    logic [23:0] e;
    @(negedge clk);
    host_we = we; host_sel = sel; host_wdata = wd; pix_idx = px; wide_en = wide;
    e = model[px];
    if (!wide) e = e & 24'hFCFCFC;
    if (chk) sbq.push_back('{e, tag, cyc + 1});
    if (we && sel) begin
      model[m_idx] = wd[23:0];
      m_idx = m_idx + 8'd1;
    end else if (we) begin
      m_idx = wd[7:0];
    end
  endtask

  task automatic wr_index(input logic [7:0] v);
    step(1, 0, {24'hDEADBE, v}, 8'h00, 1, 0, "");
  endtask

  task automatic wr_colour(input logic [31:0] w);
    step(1, 1, w, 8'h00, 1, 0, "");
  endtask

  task automatic look(input logic [7:0] px, input bit wide, input string tag);
    step(0, 1, 32'hFFFF_FFFF, px, wide, 1, tag);
  endtask

  // Monitor: compares each expectation in its due cycle.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      check(pix_rgb, it.exp, it.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 24'h0;
    m_idx = 8'h00;
    rst_n = 0; host_we = 0; host_sel = 0; host_wdata = '0; wide_en = 1; pix_idx = 0;
    repeat (3) @(negedge clk);
    check(pix_rgb, 24'h0, "R1 during reset");
    rst_n = 1;
    #1 check(pix_rgb, 24'h0, "R1 after release");

    // R1: first colour write without index write lands at entry 0
    wr_colour(32'h0012_3456);
    look(8'h00, 1, "R1 first write at entry 0");
    look(8'h00, 1, "R6 output held next cycle");

    // R3 R4: identity ramp streamed after one index write, junk in top byte
    wr_index(8'h00);
    for (int i = 0; i < 256; i++) wr_colour({8'hA5, i[7:0], i[7:0], i[7:0]});
    for (int i = 0; i < 256; i++) look(i[7:0], 1, "R4 ramp entry");

    // R5: index wrapped to 0 after 256 writes
    wr_colour(32'hFF11_2233);
    look(8'h00, 1, "R5 wrap after full ramp");
    look(8'h01, 1, "R4 neighbour untouched");

    // R5: wrap from FE
    wr_index(8'hFE);
    wr_colour(32'h00AA_0001);
    wr_colour(32'h0000_BB02);
    wr_colour(32'h0000_00C3);
    look(8'hFE, 1, "R3 red field");
    look(8'hFF, 1, "R3 green field");
    look(8'h00, 1, "R5 wrap to entry 0");

    // R7: narrow mode
    wr_index(8'h40);
    wr_colour(32'h00FF_FFFF);
    wr_colour(32'h0013_579B);
    look(8'h40, 0, "R7 narrow all ones");
    look(8'h41, 0, "R7 narrow pattern");
    look(8'h41, 1, "R7 wide pattern");
    look(8'h40, 0, "R7 narrow back to back");

    // R8: same-cycle write and lookup of the same entry
    wr_index(8'h80);
    step(1, 1, 32'h0077_8899, 8'h80, 1, 1, "R8 old value on collision");
    look(8'h80, 1, "R8 new value next cycle");

    // R9 R2: index write changes no entry, then redirects data
    step(1, 0, 32'h0000_00EF, 8'h41, 1, 1, "R9 index write leaves table");
    look(8'hEF, 1, "R9 target entry unchanged");
    wr_colour(32'h0010_2030);
    look(8'hEF, 1, "R2 write lands at loaded index");
    look(8'hF0, 1, "R2 next entry untouched");

    // R10: strobe low with colour target and data
    step(0, 1, 32'h00EE_EEEE, 8'hF0, 1, 1, "R10 idle write no effect");
    step(0, 0, 32'h0000_0005, 8'hF0, 1, 1, "R10 idle index no effect");
    wr_colour(32'h0044_5566);
    look(8'hF0, 1, "R10 index kept while idle");
    look(8'h05, 1, "R10 entry 5 unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule